// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence of a four-beat memory burst. A start address is captured when either of two address-strobe inputs is high at a rising clock edge. From then on the upper address bits are held, and the low two bits step through the burst each time the advance input is high. A mode input, captured together with the start address, picks one of two beat orders. In linear order the low bits count upward and wrap. In interleaved order the low bits are the start bits XORed with the beat count.

A strobe may arrive on any cycle, including the cycle right after another strobe or in the middle of a burst, and no cycle is lost. The outputs are the current full address and the beat index. Both come from registers, so they change one clock after the edge that caused the change. After the fourth beat, one further advance ends the burst. The counter then goes idle and ignores advances until the next strobe.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0, `beat_o` is 0 and the counter is idle, so advance pulses leave both outputs unchanged.
- R2: A high level on `strobe_a_i`, on `strobe_b_i`, or on both at a rising edge loads `addr_i`. After that edge, `addr_o` equals the loaded address and `beat_o` is 0.
- R3: A strobe is accepted on every cycle. On consecutive strobes, each loaded address appears on `addr_o` in the cycle after its own edge.
- R4: With `order_sel_i` = 1 (linear) at load, beat k has low bits equal to (start low bits + k) mod 4. Start 2 gives 2,3,0,1.
- R5: With `order_sel_i` = 0 (interleaved) at load, beat k has low bits equal to start low bits XOR k. Start 1 gives 1,0,3,2. Code 0 is interleaved, so a pulled-down or unconnected mode input gives interleaved order.
- R6: During a burst, address bits above the two low bits keep the value loaded at the strobe.
- R7: In a cycle with no strobe and no advance, `addr_o` and `beat_o` hold their values.
- R8: A strobe in the same cycle as an advance loads the new address with beat 0, and the advance is discarded.
- R9: An advance while `beat_o` is 3 ends the burst with both outputs unchanged. Later advances have no effect until the next strobe.
- R10: The order is fixed at the load. Changing `order_sel_i` during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_a_i | input | 1 | First address strobe, loads a start address |
| strobe_b_i | input | 1 | Second address strobe, same effect as the first |
| adv_i | input | 1 | Step to the next beat of the burst |
| order_sel_i | input | 1 | Beat order at load: 0 interleaved, 1 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BEAT_W | Beat index within the burst, 0 to 3 |

## Verification
A strobe and an advance can arrive in the same cycle, and the strobe must win. The bench raises both in the middle of a burst with a new address on `addr_i`. The next cycle must show the new address at beat 0, not the next beat of the old burst. A second case strobes on two consecutive cycles. The first of those cycles also carries an advance, which must be discarded. Each address must appear exactly one cycle after its edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Beat-order code; value 0 is the safe default (interleaved)
   typedef enum logic {
      ORD_INTLV  = 1'b0,
      ORD_LINEAR = 1'b1
   } order_t;

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_a_i,
   input  logic strobe_b_i,
   input  logic adv_i,
   input  logic at_last_i,
   output logic load_o,
   output logic step_o,
   output logic active_o
);

   logic finish;
   logic active_q;

   // Either strobe loads; a load always wins over an advance
   assign load_o   = strobe_a_i | strobe_b_i;
   assign step_o   = active_q & adv_i & ~load_o & ~at_last_i;
   assign finish   = active_q & adv_i & ~load_o &  at_last_i;
   assign active_o = active_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       active_q <= 1'b0;
      else if (load_o)   active_q <= 1'b1;
      else if (finish)   active_q <= 1'b0;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] count_o,
   output logic              at_last_o
);

   logic [BEAT_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      count_q <= '0;
      else if (load_i)  count_q <= '0;
      else if (step_i)  count_q <= count_q + 1'b1;
   end

   assign count_o   = count_q;
   assign at_last_o = &count_q;

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] count_i,
   input  order_t            mode_i,
   output logic [BEAT_W-1:0] offs_o
);

   logic [BEAT_W-1:0] xor_v;
   logic [BEAT_W-1:0] lin_v;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
      assign xor_v[b] = start_i[b] ^ count_i[b];
   end

   // Natural wrap of the BEAT_W-bit sum gives the modulo
   assign lin_v = start_i + count_i;

   always_comb begin
      if (mode_i == ORD_LINEAR) offs_o = lin_v;
      else                      offs_o = xor_v;
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strobe_a_i,
   input  logic              strobe_b_i,
   input  logic              adv_i,
   input  logic              order_sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BEAT_W-1:0] beat_o
);

   localparam int HI_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1)       begin : g_bad_beat  $error("BEAT_W must be at least 1"); end
   if (HI_W < 1)         begin : g_bad_addr  $error("ADDR_W must exceed BEAT_W"); end

   logic              load;
   logic              step;
   logic              active;
   logic              at_last;
   logic [BEAT_W-1:0] count;
   logic [BEAT_W-1:0] offs;
   logic [ADDR_W-1:0] base_q;
   order_t            mode_q;

   burst_ctl u_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .strobe_a_i (strobe_a_i),
      .strobe_b_i (strobe_b_i),
      .adv_i      (adv_i),
      .at_last_i  (at_last),
      .load_o     (load),
      .step_o     (step),
      .active_o   (active)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .step_i    (step),
      .count_o   (count),
      .at_last_o (at_last)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         base_q <= '0;
         mode_q <= ORD_INTLV;
      end else if (load) begin
         base_q <= addr_i;
         mode_q <= order_t'(order_sel_i);
      end
   end

   burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
      .start_i (base_q[BEAT_W-1:0]),
      .count_i (count),
      .mode_i  (mode_q),
      .offs_o  (offs)
   );

   assign addr_o = {base_q[ADDR_W-1:BEAT_W], offs};
   assign beat_o = count;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              strobe_a_i,
   input logic              strobe_b_i,
   input logic              adv_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [BEAT_W-1:0] beat_o,
   input logic              active
);

   logic strobe;
   assign strobe = strobe_a_i | strobe_b_i;

   AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe |=> addr_o == $past(addr_i)); // R2

   AST_LOAD_BEAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe && adv_i) |=> beat_o == '0); // R8

   AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strobe && !adv_i) |=> ($stable(addr_o) && $stable(beat_o))); // R7

   AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strobe |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R6

   AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && adv_i && !strobe && !(&beat_o)) |=> beat_o == $past(beat_o) + 1'b1); // R4

   AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!active && !strobe) |=> ($stable(addr_o) && $stable(beat_o))); // R9

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .strobe_a_i (strobe_a_i),
   .strobe_b_i (strobe_b_i),
   .adv_i      (adv_i),
   .addr_i     (addr_i),
   .addr_o     (addr_o),
   .beat_o     (beat_o),
   .active     (active)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

   localparam int AW = 12;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sa = 1'b0, sb = 1'b0, adv = 1'b0, ord = 1'b0;
   logic [AW-1:0] a_in = '0;
   logic [AW-1:0] a_out;
   logic [BW-1:0] beat;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
      .clk_i(clk), .rst_ni(rst_n), .strobe_a_i(sa), .strobe_b_i(sb),
      .adv_i(adv), .order_sel_i(ord), .addr_i(a_in), .addr_o(a_out), .beat_o(beat)
   );

   function automatic logic [BW-1:0] exp_low(logic [BW-1:0] s, int k, logic lin);
      logic [BW-1:0] kk = BW'(k);
      return lin ? BW'(s + kk) : (s ^ kk);
   endfunction

   task automatic chk(string req, logic [AW-1:0] got_a, logic [AW-1:0] exp_a,
                      logic [BW-1:0] got_b, logic [BW-1:0] exp_b);
      total++;
      if (got_a !== exp_a || got_b !== exp_b) begin
         bad++;
         $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                  req, got_a, got_b, exp_a, exp_b);
      end
   endtask

   // One clock: drive at negedge, outputs observed shortly after the edge
   task automatic cyc(logic s_a, logic s_b, logic v, logic o, logic [AW-1:0] a);
      @(negedge clk);
      sa = s_a; sb = s_b; adv = v; ord = o; a_in = a;
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset;
      chk("R1 reset", a_out, '0, beat, '0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 12'hFFF);
      chk("R1 idle adv", a_out, '0, beat, '0);
   endtask

   task automatic t_linear;
      logic [AW-1:0] s = 12'hAB6;
      cyc(1, 0, 0, 1, s);
      chk("R2 load a", a_out, s, beat, 0);
      for (int k = 1; k < 4; k++) begin
         cyc(0, 0, 1, 1, 12'h000);
         chk("R4 R6 linear", a_out, {s[AW-1:BW], exp_low(s[BW-1:0], k, 1'b1)}, beat, BW'(k));
      end
   endtask

   task automatic t_interleave;
      logic [AW-1:0] s = 12'h5A1;
      cyc(0, 1, 0, 0, s);
      chk("R2 load b", a_out, s, beat, 0);
      for (int k = 1; k < 4; k++) begin
         cyc(0, 0, 1, 0, 12'hFFF);
         chk("R5 R6 intlv", a_out, {s[AW-1:BW], exp_low(s[BW-1:0], k, 1'b0)}, beat, BW'(k));
      end
   endtask

   task automatic t_end_of_burst;
      logic [AW-1:0] s = 12'h3C2;
      logic [AW-1:0] last;
      cyc(1, 0, 0, 1, s);
      for (int k = 1; k < 4; k++) cyc(0, 0, 1, 1, '0);
      last = {s[AW-1:BW], exp_low(s[BW-1:0], 3, 1'b1)};
      chk("R9 beat3", a_out, last, beat, 3);
      cyc(0, 0, 1, 1, '0);
      chk("R9 end adv", a_out, last, beat, 3);
      cyc(0, 0, 1, 0, '0);
      cyc(0, 0, 1, 0, '0);
      chk("R9 idle adv", a_out, last, beat, 3);
   endtask

   task automatic t_hold;
      logic [AW-1:0] s = 12'h713;
      cyc(1, 0, 0, 0, s);
      cyc(0, 0, 1, 0, '0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 12'h0AA);
      chk("R7 hold", a_out, {s[AW-1:BW], exp_low(s[BW-1:0], 1, 1'b0)}, beat, 1);
   endtask

   task automatic t_priority;
      logic [AW-1:0] s = 12'h140;
      logic [AW-1:0] n = 12'h9E7;
      cyc(1, 0, 0, 1, s);
      cyc(0, 0, 1, 1, '0);
      cyc(0, 1, 1, 0, n);
      chk("R8 strobe wins", a_out, n, beat, 0);
      cyc(0, 0, 1, 0, '0);
      chk("R8 new burst", a_out, {n[AW-1:BW], exp_low(n[BW-1:0], 1, 1'b0)}, beat, 1);
   endtask

   task automatic t_back_to_back;
      cyc(1, 0, 1, 0, 12'h111);
      chk("R3 first", a_out, 12'h111, beat, 0);
      cyc(0, 1, 0, 0, 12'h222);
      chk("R3 second", a_out, 12'h222, beat, 0);
      cyc(1, 1, 0, 1, 12'h333);
      chk("R2 R3 both", a_out, 12'h333, beat, 0);
   endtask

   task automatic t_order_capture;
      logic [AW-1:0] s = 12'h865;
      cyc(1, 0, 0, 1, s);
      for (int k = 1; k < 4; k++) begin
         cyc(0, 0, 1, 0, '0);
         chk("R10 order held", a_out, {s[AW-1:BW], exp_low(s[BW-1:0], k, 1'b1)}, beat, BW'(k));
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_linear();
      t_interleave();
      t_end_of_burst();
      t_hold();
      t_priority();
      t_back_to_back();
      t_order_capture();
      cyc(0, 0, 0, 0, '0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule